// File: doc/BRIEF.md
# Video Encoder Status Readback Bank

This block is the read side of a video encoder's control register space. The serial control engine hands it a decoded subaddress with a read strobe or a write strobe, and the block returns one data byte. Three locations can be read. The first is a status byte, which carries a fixed version code, the caption-done flags, the sequence-start marker and the current field parity. The second is a chip identification byte. The third is a FIFO error byte.

The encoder core drives the block with single-cycle event pulses. One pulse per field marks that the odd-field or even-field closed-caption bytes have been encoded. Another pulse marks the start of a field. Separate pulses report FIFO overflows and underflows. A level input gives the parity of the current field, and another level input selects the video standard, which sets the sequence length to 4 or 8 fields. Writes are only observed to clear the caption flags: a write to either caption data location of a field clears that field's done flag.

Top module: `vstat_regs`

## Requirements
- R1: After synchronous reset, `rd_data` is 00H, all flags are 0, and the field counter is 0. The sequence-start bit therefore reads 1.
- R2: When `rd_en` is high at a clock edge, `rd_data` presents the addressed byte from that edge onward. Without `rd_en`, `rd_data` holds its value.
- R3: The status byte at subaddress 00H has this layout: bits 7:5 = 101b, bit 4 = odd caption done, bit 3 = even caption done, bit 2 = 0, bit 1 = sequence start, bit 0 = `field_even` (1 for an even field, 0 for an odd field).
- R4: The odd caption done flag sets one edge after `cc_odd_done`. It clears after a write to subaddress 67H or 68H.
- R5: The even caption done flag sets one edge after `cc_even_done`. It clears after a write to subaddress 69H or 6AH.
- R6: If a done pulse and a clearing write reach the same flag in the same cycle, the flag ends up set.
- R7: A counter advances on each `field_start` and wraps after 4 fields when `pal_mode`=0, or after 8 fields when `pal_mode`=1. The sequence-start bit is 1 only while the counter is 0.
- R8: A change of `pal_mode` from its value in the previous cycle returns the counter to 0 at the next edge. This takes priority over `field_start`.
- R9: A read of subaddress 1CH returns the parameter `CHIP_ID` (default 04H).
- R10: In the FIFO byte at 80H, bit 1 (overflow) and bit 0 (underflow) latch on `fifo_ovf` and `fifo_udf`. A read of 80H returns the flags' current values and then clears them.
- R11: An overflow or underflow event in the same cycle as a clearing read of 80H leaves that flag set.
- R12: Bit 3 of the FIFO byte latches on `in_fifo_ovf` or `in_fifo_udf`. Bit 2 latches on `buf_fifo_ovf` only while `upsample_en`=1. Neither bit is cleared by a read, and bits 7:4 read 0.
- R13: A read of any other subaddress returns 00H. A write to any subaddress other than 67H to 6AH changes no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sub_addr | input | 8 | Subaddress for the current read or write |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| rd_data | output | 8 | Registered read data |
| cc_odd_done | input | 1 | Pulse: odd-field caption bytes encoded |
| cc_even_done | input | 1 | Pulse: even-field caption bytes encoded |
| field_start | input | 1 | Pulse: a new field begins |
| field_even | input | 1 | Level: current field is even |
| pal_mode | input | 1 | Standard select: 0 gives 4-field sequence, 1 gives 8-field sequence |
| fifo_ovf | input | 1 | Pulse: FIFO overflow |
| fifo_udf | input | 1 | Pulse: FIFO underflow |
| in_fifo_ovf | input | 1 | Pulse: input FIFO overflow |
| in_fifo_udf | input | 1 | Pulse: input FIFO underflow |
| buf_fifo_ovf | input | 1 | Pulse: buffer FIFO overflow |
| upsample_en | input | 1 | Level: upsampling path enabled |

## Verification
Each flag and the field counter is one register stage. An event in cycle N can therefore first be seen by a read strobed in cycle N+1, and that read's data appears on `rd_data` after the edge that ends cycle N+1. The bench keeps a reference state that it advances once per clock from the same inputs. It computes the expected byte from the pre-edge state when it issues a read, and it compares `rd_data` one time unit after that edge. Directed sequences place the edge cases in a single cycle: a done pulse together with a clearing write, an overflow together with a clearing read, a buffer overflow with upsampling off, and a standard change together with a field start.

// File: rtl/vstat_pkg.sv
package vstat_pkg;

    localparam logic [7:0] SA_STATUS   = 8'h00;
    localparam logic [7:0] SA_CHIPID   = 8'h1C;
    localparam logic [7:0] SA_FIFO     = 8'h80;
    localparam logic [7:0] SA_ODD_LO   = 8'h67;
    localparam logic [7:0] SA_ODD_HI   = 8'h68;
    localparam logic [7:0] SA_EVEN_LO  = 8'h69;
    localparam logic [7:0] SA_EVEN_HI  = 8'h6A;
    localparam logic [2:0] VERSION_CODE = 3'b101;

    typedef enum logic {
        STD_NTSC = 1'b0,
        STD_PAL  = 1'b1
    } video_std_e;

    typedef struct packed {
        logic cc_odd;
        logic cc_even;
        logic seq_first;
        logic field_even;
    } status_t;

    typedef struct packed {
        logic in_err;
        logic buf_err;
        logic ovf;
        logic udf;
    } fifo_flags_t;

    function automatic logic [7:0] pack_status(input status_t s);
        return {VERSION_CODE, s.cc_odd, s.cc_even, 1'b0, s.seq_first, s.field_even};
    endfunction

    function automatic logic [7:0] pack_fifo(input fifo_flags_t f);
        return {4'b0000, f.in_err, f.buf_err, f.ovf, f.udf};
    endfunction

endpackage

// File: rtl/vstat_cc_flag.sv
module vstat_cc_flag #(
    parameter logic [7:0] CLR_LO = 8'h67,
    parameter logic [7:0] CLR_HI = 8'h68
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wr_addr,
    input  logic       done,
    output logic       flag
);

    logic clr_hit;
    assign clr_hit = wr_en && ((wr_addr == CLR_LO) || (wr_addr == CLR_HI));

    always_ff @(posedge clk) begin
        if (rst)          flag <= 1'b0;
        else if (done)    flag <= 1'b1;
        else if (clr_hit) flag <= 1'b0;
    end

    // R4 R5 R6
    cc_set_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> flag);

    // R4 R5
    cc_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (wr_addr == CLR_LO || wr_addr == CLR_HI) && !done) |=> !flag);

    // R13
    cc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!done && !(wr_en && (wr_addr == CLR_LO || wr_addr == CLR_HI))) |=> $stable(flag));

endmodule

// File: rtl/vstat_field_seq.sv
module vstat_field_seq
    import vstat_pkg::*;
#(
    parameter int NTSC_FIELDS = 4,
    parameter int PAL_FIELDS  = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       field_start,
    input  video_std_e std,
    output logic       seq_first
);

    localparam int MAX_FIELDS = (PAL_FIELDS > NTSC_FIELDS) ? PAL_FIELDS : NTSC_FIELDS;
    localparam int CNT_W      = (MAX_FIELDS > 1) ? $clog2(MAX_FIELDS) : 1;
    localparam logic [CNT_W-1:0] LAST_NTSC = CNT_W'(NTSC_FIELDS - 1);
    localparam logic [CNT_W-1:0] LAST_PAL  = CNT_W'(PAL_FIELDS - 1);

    video_std_e       std_q;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last;
    logic             std_change;

    assign last       = (std == STD_PAL) ? LAST_PAL : LAST_NTSC;
    assign std_change = (std != std_q);
    assign seq_first  = (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            std_q <= STD_NTSC;
            cnt   <= '0;
        end else begin
            std_q <= std;
            if (std_change)
                cnt <= '0;
            else if (field_start)
                cnt <= (cnt == last) ? '0 : cnt + 1'b1;
        end
    end

    // R7
    seq_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (field_start && !std_change && cnt == last) |=> seq_first);

    // R7
    seq_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!field_start && !std_change) |=> $stable(cnt));

    // R8
    seq_restart_chk: assert property (@(posedge clk) disable iff (rst)
        std_change |=> seq_first);

endmodule

// File: rtl/vstat_fifo_err.sv
module vstat_fifo_err
    import vstat_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        ovf_ev,
    input  logic        udf_ev,
    input  logic        in_ovf_ev,
    input  logic        in_udf_ev,
    input  logic        buf_ovf_ev,
    input  logic        upsample_en,
    input  logic        clr_rd,
    output fifo_flags_t flags
);

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
        end else begin
            flags.ovf     <= (flags.ovf & ~clr_rd) | ovf_ev;
            flags.udf     <= (flags.udf & ~clr_rd) | udf_ev;
            flags.in_err  <= flags.in_err | in_ovf_ev | in_udf_ev;
            flags.buf_err <= flags.buf_err | (buf_ovf_ev & upsample_en);
        end
    end

    // R10 R11
    ovf_latch_chk: assert property (@(posedge clk) disable iff (rst)
        ovf_ev |=> flags.ovf);

    // R10 R11
    udf_latch_chk: assert property (@(posedge clk) disable iff (rst)
        udf_ev |=> flags.udf);

    // R10
    ovf_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_rd && !ovf_ev) |=> !flags.ovf);

    // R12
    in_err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        flags.in_err |=> flags.in_err);

    // R12
    buf_err_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (!flags.buf_err && !upsample_en) |=> !flags.buf_err);

endmodule

// File: rtl/vstat_regs.sv
module vstat_regs
    import vstat_pkg::*;
#(
    parameter logic [7:0] CHIP_ID     = 8'h04,
    parameter int         NTSC_FIELDS = 4,
    parameter int         PAL_FIELDS  = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] sub_addr,
    input  logic       rd_en,
    input  logic       wr_en,
    output logic [7:0] rd_data,
    input  logic       cc_odd_done,
    input  logic       cc_even_done,
    input  logic       field_start,
    input  logic       field_even,
    input  logic       pal_mode,
    input  logic       fifo_ovf,
    input  logic       fifo_udf,
    input  logic       in_fifo_ovf,
    input  logic       in_fifo_udf,
    input  logic       buf_fifo_ovf,
    input  logic       upsample_en
);

    localparam int          NUM_CC = 2;
    localparam logic [15:0] CC_LO  = {SA_EVEN_LO, SA_ODD_LO};
    localparam logic [15:0] CC_HI  = {SA_EVEN_HI, SA_ODD_HI};

    logic [NUM_CC-1:0] cc_done;
    logic [NUM_CC-1:0] cc_flag;
    logic              seq_first;
    fifo_flags_t       fifo_flags;
    status_t           status;
    logic [7:0]        rd_next;
    logic              fifo_rd;

    assign cc_done = {cc_even_done, cc_odd_done};

    for (genvar g = 0; g < NUM_CC; g++) begin : g_cc
        vstat_cc_flag #(
            .CLR_LO (CC_LO[g*8 +: 8]),
            .CLR_HI (CC_HI[g*8 +: 8])
        ) i_flag (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (wr_en),
            .wr_addr (sub_addr),
            .done    (cc_done[g]),
            .flag    (cc_flag[g])
        );
    end

    vstat_field_seq #(
        .NTSC_FIELDS (NTSC_FIELDS),
        .PAL_FIELDS  (PAL_FIELDS)
    ) i_seq (
        .clk         (clk),
        .rst         (rst),
        .field_start (field_start),
        .std         (video_std_e'(pal_mode)),
        .seq_first   (seq_first)
    );

    assign fifo_rd = rd_en && (sub_addr == SA_FIFO);

    vstat_fifo_err i_fifo (
        .clk         (clk),
        .rst         (rst),
        .ovf_ev      (fifo_ovf),
        .udf_ev      (fifo_udf),
        .in_ovf_ev   (in_fifo_ovf),
        .in_udf_ev   (in_fifo_udf),
        .buf_ovf_ev  (buf_fifo_ovf),
        .upsample_en (upsample_en),
        .clr_rd      (fifo_rd),
        .flags       (fifo_flags)
    );

    always_comb begin
        status.cc_odd     = cc_flag[0];
        status.cc_even    = cc_flag[1];
        status.seq_first  = seq_first;
        status.field_even = field_even;
        case (sub_addr)
            SA_STATUS: rd_next = pack_status(status);
            SA_CHIPID: rd_next = CHIP_ID;
            SA_FIFO:   rd_next = pack_fifo(fifo_flags);
            default:   rd_next = 8'h00;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)        rd_data <= 8'h00;
        else if (rd_en) rd_data <= rd_next;
    end

    // R2
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_data));

    // R13
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && sub_addr != SA_STATUS && sub_addr != SA_CHIPID && sub_addr != SA_FIFO)
        |=> (rd_data == 8'h00));

    // R9
    chip_id_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && sub_addr == SA_CHIPID) |=> (rd_data == CHIP_ID));

    // R3
    status_version_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && sub_addr == SA_STATUS) |=> (rd_data[7:5] == 3'b101 && !rd_data[2]));

endmodule

// File: tb/test_vstat_regs.sv
`timescale 1ns/1ps
module test_vstat_regs;

    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] sub_addr;
    logic       rd_en, wr_en;
    logic [7:0] rd_data;
    logic       cc_odd_done, cc_even_done, field_start, field_even, pal_mode;
    logic       fifo_ovf, fifo_udf, in_fifo_ovf, in_fifo_udf, buf_fifo_ovf, upsample_en;

    int checks = 0;
    int errors = 0;
    bit done_flag = 0;

    // reference state
    bit m_odd, m_even, m_std_q, m_ovf, m_udf, m_ierr, m_berr;
    int m_cnt;
    logic [7:0] m_rd;

    always #2.5 clk = ~clk;

    vstat_regs i_vstat_regs (
        .clk(clk), .rst(rst), .sub_addr(sub_addr), .rd_en(rd_en), .wr_en(wr_en),
        .rd_data(rd_data), .cc_odd_done(cc_odd_done), .cc_even_done(cc_even_done),
        .field_start(field_start), .field_even(field_even), .pal_mode(pal_mode),
        .fifo_ovf(fifo_ovf), .fifo_udf(fifo_udf), .in_fifo_ovf(in_fifo_ovf),
        .in_fifo_udf(in_fifo_udf), .buf_fifo_ovf(buf_fifo_ovf), .upsample_en(upsample_en)
    );

    function automatic logic [7:0] exp_byte(input logic [7:0] a);
        case (a)
            8'h00:   return {3'b101, m_odd, m_even, 1'b0, (m_cnt == 0), field_even};
            8'h1C:   return 8'h04;
            8'h80:   return {4'b0, m_ierr, m_berr, m_ovf, m_udf};
            default: return 8'h00;
        endcase
    endfunction

    function automatic string tag_of(input logic [7:0] a);
        case (a)
            8'h00:   return "R3";
            8'h1C:   return "R9";
            8'h80:   return "R10";
            default: return "R13";
        endcase
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: rd_data=%02h expected=%02h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic idle_inputs();
        rd_en = 0; wr_en = 0; sub_addr = 8'h00;
        cc_odd_done = 0; cc_even_done = 0; field_start = 0;
        fifo_ovf = 0; fifo_udf = 0; in_fifo_ovf = 0; in_fifo_udf = 0; buf_fifo_ovf = 0;
    endtask

    // one clock: advance the reference model, then compare after the edge
    task automatic tick(input string req);
        bit did_rd = rd_en;
        bit clr_o, clr_e, fifo_clr;
        int last;
        logic [7:0] a = sub_addr;
        if (rd_en) m_rd = exp_byte(sub_addr);
        clr_o = wr_en && (sub_addr == 8'h67 || sub_addr == 8'h68);
        clr_e = wr_en && (sub_addr == 8'h69 || sub_addr == 8'h6A);
        fifo_clr = rd_en && sub_addr == 8'h80;
        if (cc_odd_done) m_odd = 1; else if (clr_o) m_odd = 0;
        if (cc_even_done) m_even = 1; else if (clr_e) m_even = 0;
        last = pal_mode ? 7 : 3;
        if (pal_mode != m_std_q) m_cnt = 0;
        else if (field_start) m_cnt = (m_cnt == last) ? 0 : m_cnt + 1;
        m_std_q = pal_mode;
        m_ovf = (m_ovf && !fifo_clr) || fifo_ovf;
        m_udf = (m_udf && !fifo_clr) || fifo_udf;
        m_ierr = m_ierr || in_fifo_ovf || in_fifo_udf;
        m_berr = m_berr || (buf_fifo_ovf && upsample_en);
        @(posedge clk);
        #1;
        if (did_rd) check((req == "") ? tag_of(a) : req, rd_data, m_rd);
        else if (req == "R2") check("R2", rd_data, m_rd);
        idle_inputs();
    endtask

    task automatic do_read(input logic [7:0] a, input string req);
        sub_addr = a; rd_en = 1; tick(req);
    endtask

    task automatic do_reset();
        rst = 1; idle_inputs();
        @(posedge clk); @(posedge clk); #1;
        m_odd = 0; m_even = 0; m_ovf = 0; m_udf = 0; m_ierr = 0; m_berr = 0;
        m_cnt = 0; m_std_q = 0; m_rd = 8'h00;
        rst = 0;
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done_flag) begin
            errors++;
            $display("FAIL watchdog: expired, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1729));
        field_even = 0; pal_mode = 0; upsample_en = 0;
        do_reset();

        // R1: reset state
        check("R1", rd_data, 8'h00);
        do_read(8'h00, "R1");                 // A2: version, seq start, odd parity
        do_read(8'h80, "R1");
        do_read(8'h1C, "R9");

        // R4 set then clear via 68H
        cc_odd_done = 1; tick("");
        do_read(8'h00, "R4");
        sub_addr = 8'h68; wr_en = 1; tick("");
        do_read(8'h00, "R4");
        // R5 set then clear via 69H
        cc_even_done = 1; tick("");
        do_read(8'h00, "R5");
        sub_addr = 8'h69; wr_en = 1; tick("");
        do_read(8'h00, "R5");
        // R6: set wins over clearing write in the same cycle
        cc_even_done = 1; sub_addr = 8'h6A; wr_en = 1; tick("");
        do_read(8'h00, "R6");
        // R13: write elsewhere leaves flag
        sub_addr = 8'h66; wr_en = 1; tick("");
        do_read(8'h00, "R13");
        do_read(8'h55, "R13");
        // R2: hold without read strobe
        sub_addr = 8'h1C; tick("R2");

        // R7: NTSC wrap after 4 fields
        for (int i = 0; i < 4; i++) begin field_start = 1; tick(""); end
        do_read(8'h00, "R7");
        // R8: switch to PAL together with a field start
        pal_mode = 1; field_start = 1; tick("");
        do_read(8'h00, "R8");
        for (int i = 0; i < 7; i++) begin field_start = 1; tick(""); end
        do_read(8'h00, "R7");
        field_start = 1; tick("");
        do_read(8'h00, "R7");

        // R10: latch and clear on read
        fifo_ovf = 1; fifo_udf = 1; tick("");
        do_read(8'h80, "R10");
        do_read(8'h80, "R10");
        // R11: event with clearing read
        fifo_ovf = 1; tick("");
        sub_addr = 8'h80; rd_en = 1; fifo_ovf = 1; tick("R11");
        do_read(8'h80, "R11");
        // R12: buffer error gated by upsampling, input error sticky
        upsample_en = 0; buf_fifo_ovf = 1; in_fifo_udf = 1; tick("");
        do_read(8'h80, "R12");
        do_read(8'h80, "R12");
        upsample_en = 1; buf_fifo_ovf = 1; tick("");
        do_read(8'h80, "R12");

        // constrained random traffic
        for (int n = 0; n < 4000; n++) begin
            int r = $urandom_range(0, 99);
            if (r < 35) begin
                rd_en = 1;
                case ($urandom_range(0, 4))
                    0, 1: sub_addr = 8'h00;
                    2: sub_addr = 8'h80;
                    3: sub_addr = 8'h1C;
                    default: sub_addr = 8'($urandom);
                endcase
            end else if (r < 50) begin
                wr_en = 1;
                sub_addr = ($urandom_range(0, 3) == 0) ? 8'($urandom)
                                                       : 8'h67 + 8'($urandom_range(0, 3));
            end
            cc_odd_done  = ($urandom_range(0, 15) == 0);
            cc_even_done = ($urandom_range(0, 15) == 0);
            fifo_ovf     = ($urandom_range(0, 19) == 0);
            fifo_udf     = ($urandom_range(0, 19) == 0);
            in_fifo_ovf  = ($urandom_range(0, 199) == 0);
            in_fifo_udf  = ($urandom_range(0, 199) == 0);
            buf_fifo_ovf = ($urandom_range(0, 49) == 0);
            field_start  = ($urandom_range(0, 7) == 0);
            if (field_start) field_even = ~field_even;
            if ($urandom_range(0, 299) == 0) pal_mode = ~pal_mode;
            if ($urandom_range(0, 99) == 0) upsample_en = ~upsample_en;
            if ($urandom_range(0, 999) == 0) begin
                do_reset();
                check("R1", rd_data, 8'h00);
            end else begin
                tick("");
            end
        end

        done_flag = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule